// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Scanner

This block drives a four-digit seven-segment LED display whose segment lines are shared by all digits: every digit's segment a sits on one common line, every digit's segment b on another, and so on through g. Because the lines are shared, only one digit may be enabled at a time. The block takes four 4-bit decimal digit values (units, tens, hundreds and thousands) and shows them by lighting the digits in turn, one after another, quickly enough that the eye sees all four at once.

A prescaler produces a one-cycle tick every `CLK_HZ / SCAN_HZ` clocks. With the defaults (50 MHz, 1 kHz) that is every 50,000 clocks, so each digit is lit for one millisecond. A four-state scan machine picks the active position: UNITS, TENS, HUNDREDS, THOUSANDS. On each tick it takes the transition to the next state, and from THOUSANDS it goes back to UNITS. The two-bit state wraps on its own, so the wrap needs no explicit clear. The selected digit value goes through one shared decoder. The segment vector and the digit-enable vector are both registered, so they change together on the same edge. Setting `ACTIVE_LOW` to 1 inverts both outputs for common-anode displays.

Top module: `seg7_scan_top`

## Requirements
- R1: While `rst_n` is low, no digit is enabled and no segment is lit. With `ACTIVE_LOW`=0 both outputs read 0; with `ACTIVE_LOW`=1 both read all ones.
- R2: From the first clock edge after reset release, exactly one bit of the lit-sense `dig_en` is set in every cycle.
- R3: The enabled position follows the order units (dig_en bit 0), tens (bit 1), hundreds (bit 2), thousands (bit 3), then back to units.
- R4: Each position is held for exactly `CLK_HZ/SCAN_HZ` clock cycles. After the n-th edge following reset release (n counted from 1), the shown position is ((n-1) / (CLK_HZ/SCAN_HZ)) mod 4.
- R5: Digit codes 0 to 9 drive `seg` in the bit order a..g, with a as bit 6 (MSB), and 1 meaning lit. The patterns are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R6: Digit codes 10 to 15 light no segment.
- R7: With `ACTIVE_LOW`=1, `seg` and `dig_en` are the bitwise complement of the values the same block gives with `ACTIVE_LOW`=0.
- R8: `seg` and `dig_en` are registered together. After each edge, `seg` shows the decoded value of the input that belonged to the newly enabled position at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| units | input | 4 | Digit value for position 0 |
| tens | input | 4 | Digit value for position 1 |
| hundreds | input | 4 | Digit value for position 2 |
| thousands | input | 4 | Digit value for position 3 |
| seg | output | 7 | Shared segment lines, a at bit 6 down to g at bit 0 |
| dig_en | output | 4 | Digit enables, bit 0 is units |

## Verification
The bench runs with a four-clock dwell and sweeps all sixteen codes through every position. Each position gets a different code in each phase, so a design that mixed up the digit-select mapping would light the wrong pattern. Every cycle is compared against the position predicted from the edge count, which exposes an off-by-one in the prescaler or a scan order that skips or repeats a digit. Segment patterns are derived from segment geometry rules rather than a copied table, so a design that showed a stray pattern for codes 10 to 15 would be caught. A second, inverted instance catches a design that flips only one of the two output vectors.

// File: rtl/seg7_scan_pkg.sv
package seg7_scan_pkg;

    localparam int unsigned NUM_POS = 4;
    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned SEG_W   = 7;

    typedef enum logic [1:0] {
        POS_UNITS     = 2'd0,
        POS_TENS      = 2'd1,
        POS_HUNDREDS  = 2'd2,
        POS_THOUSANDS = 2'd3
    } scan_pos_e;

endpackage

// File: rtl/seg7_tick_gen.sv
module seg7_tick_gen #(
    parameter int unsigned DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

    // R4: the count never passes the end of its window
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R4: ticks are isolated single cycles
            p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/seg7_scan_fsm.sv
module seg7_scan_fsm
    import seg7_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    output scan_pos_e pos
);
    scan_pos_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POS_UNITS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                POS_UNITS:     state_d = POS_TENS;
                POS_TENS:      state_d = POS_HUNDREDS;
                POS_HUNDREDS:  state_d = POS_THOUSANDS;
                POS_THOUSANDS: state_d = POS_UNITS;
                default:       state_d = POS_UNITS;
            endcase
        end
    end

    assign pos = state_q;

    // R3: position holds between ticks
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    // R3: a tick steps exactly one position, wrapping after thousands
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (2'(state_q) == 2'($past(2'(state_q)) + 2'd1)));

endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
    import seg7_scan_pkg::*;
(
    input  logic [DIGIT_W-1:0] code,
    output logic [SEG_W-1:0]   segs
);
    always_comb begin
        unique case (code)
            4'd0:    segs = 7'b1111110;
            4'd1:    segs = 7'b0110000;
            4'd2:    segs = 7'b1101101;
            4'd3:    segs = 7'b1111001;
            4'd4:    segs = 7'b0110011;
            4'd5:    segs = 7'b1011011;
            4'd6:    segs = 7'b1011111;
            4'd7:    segs = 7'b1110000;
            4'd8:    segs = 7'b1111111;
            4'd9:    segs = 7'b1111011;
            default: segs = 7'b0000000;
        endcase
    end

endmodule

// File: rtl/seg7_scan_top.sv
module seg7_scan_top
    import seg7_scan_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned SCAN_HZ    = 1000,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIGIT_W-1:0]   units,
    input  logic [DIGIT_W-1:0]   tens,
    input  logic [DIGIT_W-1:0]   hundreds,
    input  logic [DIGIT_W-1:0]   thousands,
    output logic [SEG_W-1:0]     seg,
    output logic [NUM_POS-1:0]   dig_en
);
    localparam int unsigned TICK_DIV = (CLK_HZ / SCAN_HZ > 0) ? CLK_HZ / SCAN_HZ : 1;
    localparam logic [SEG_W-1:0]   SEG_MASK = {SEG_W{ACTIVE_LOW}};
    localparam logic [NUM_POS-1:0] EN_MASK  = {NUM_POS{ACTIVE_LOW}};

    logic               tick;
    scan_pos_e          pos;
    logic [DIGIT_W-1:0] sel_code;
    logic [SEG_W-1:0]   seg_raw;
    logic [NUM_POS-1:0] pos_onehot;
    logic [SEG_W-1:0]   seg_q;
    logic [NUM_POS-1:0] en_q;

    seg7_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    seg7_scan_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pos   (pos)
    );

    always_comb begin
        unique case (pos)
            POS_UNITS:     sel_code = units;
            POS_TENS:      sel_code = tens;
            POS_HUNDREDS:  sel_code = hundreds;
            POS_THOUSANDS: sel_code = thousands;
            default:       sel_code = units;
        endcase
    end

    seg7_decoder u_dec (
        .code (sel_code),
        .segs (seg_raw)
    );

    generate
        for (genvar i = 0; i < NUM_POS; i++) begin : g_en
            assign pos_onehot[i] = (2'(pos) == 2'(i));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_MASK;
            en_q  <= EN_MASK;
        end else begin
            seg_q <= seg_raw ^ SEG_MASK;
            en_q  <= pos_onehot ^ EN_MASK;
        end
    end

    assign seg    = seg_q;
    assign dig_en = en_q;

    logic [SEG_W-1:0]   seg_lit;
    logic [NUM_POS-1:0] en_lit;
    assign seg_lit = seg_q ^ SEG_MASK;
    assign en_lit  = en_q ^ EN_MASK;

    // R2: never more than one digit lit on the shared lines
    p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(en_lit) <= 1);

    // R6: a code above nine leaves every segment dark on the next cycle
    p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code > 4'd9) |=> (seg_lit == '0));

    // R8: segments are only lit while some digit is enabled
    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lit == '0) |-> (seg_lit == '0));

endmodule

// File: tb/test_seg7_scan_top.sv
module test_seg7_scan_top;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] units = '0, tens = '0, hundreds = '0, thousands = '0;
    logic [6:0] seg, seg_n;
    logic [3:0] dig_en, dig_en_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg7_scan_top #(.CLK_HZ(DIV), .SCAN_HZ(1), .ACTIVE_LOW(1'b0)) i_seg7_scan_top (
        .clk(clk), .rst_n(rst_n), .units(units), .tens(tens),
        .hundreds(hundreds), .thousands(thousands), .seg(seg), .dig_en(dig_en)
    );

    seg7_scan_top #(.CLK_HZ(DIV), .SCAN_HZ(1), .ACTIVE_LOW(1'b1)) i_seg7_scan_top_low (
        .clk(clk), .rst_n(rst_n), .units(units), .tens(tens),
        .hundreds(hundreds), .thousands(thousands), .seg(seg_n), .dig_en(dig_en_n)
    );

    // Segment pattern from geometry rules, bit 6 = a ... bit 0 = g
    function automatic logic [6:0] expect_seg(input logic [3:0] d);
        logic [6:0] s;
        if (d > 4'd9) return 7'b0;
        s[6] = !(d == 1 || d == 4);
        s[5] = !(d == 5 || d == 6);
        s[4] = (d != 2);
        s[3] = !(d == 1 || d == 4 || d == 7);
        s[2] = (d == 0 || d == 2 || d == 6 || d == 8);
        s[1] = !(d == 1 || d == 2 || d == 3 || d == 7);
        s[0] = !(d == 0 || d == 1 || d == 7);
        return s;
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state in both polarities
        check("R1 seg", seg, 7'b0);
        check("R1 en", {3'b0, dig_en}, 7'b0);
        check("R1 seg_low", seg_n, 7'h7F);
        check("R1 en_low", {3'b0, dig_en_n}, 7'h0F);

        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        for (int ph = 0; ph < 20; ph++) begin
            units     = 4'(ph);
            tens      = 4'(ph + 5);
            hundreds  = 4'(ph + 10);
            thousands = 4'(ph + 15);
            for (int c = 0; c < 4 * DIV + (ph % 3); c++) begin
                int p;
                logic [3:0] d;
                logic [3:0] een;
                logic [6:0] eseg;
                @(posedge clk);
                #1;
                n++;
                p = ((n - 1) / DIV) % 4;
                d = (p == 0) ? units : (p == 1) ? tens : (p == 2) ? hundreds : thousands;
                een = 4'b0001 << p;
                eseg = expect_seg(d);
                // R2 R3 R4: one enable, in order, with correct dwell
                check("R2_R3_R4 en", {3'b0, dig_en}, {3'b0, een});
                // R5 R6 R8: pattern of the newly enabled position
                check((d > 9) ? "R6 seg" : "R5_R8 seg", seg, eseg);
                // R7: inverted instance
                check("R7 seg_low", seg_n, ~eseg);
                check("R7 en_low", {3'b0, dig_en_n}, {3'b0, ~een});
                if (c == 4 * DIV + (ph % 3) - 1) @(negedge clk);
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule